// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as seven packed-BCD registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A free-running enable pulse at 32.768 kHz feeds a prescaler. Once every `PRESCALE` enables the prescaler issues a one-cycle tick, and that tick carries through every field in the same clock cycle. The hours register runs in either a 12-hour encoding with an AM/PM flag or a 24-hour encoding. The day of the month wraps at the true end of each month, and February gets a 29th day in leap years.

A host sets the time through a single-cycle synchronous write port that selects one register by address. All seven registers are visible on output ports at all times. The top bit of the seconds register stops the time base. Writing the seconds register restarts the sub-second count, so the next second begins a full period after that write.

Top module: `bcdcal_top`

## Requirements
- R1: After reset the outputs read seconds 0x00 (halt bit 0), minutes 0x00, hours 0x00 (24-hour), day of week 0x01, date 0x01, month 0x01, year 0x00.
- R2: With the halt bit clear, the `PRESCALE`-th enable after the last seconds write advances seconds by one in BCD at that same clock edge, and `sec_pulse` is high during that cycle.
- R3: While seconds bit 7 is 1, enables produce no `sec_pulse` and no register changes. Clearing the bit lets counting resume.
- R4: A write to address 0 clears the sub-second count, so the next advance needs a full `PRESCALE` enables after the write.
- R5: Seconds and minutes count 00 to 59 in BCD. At 59 they return to 00 and carry into the next field.
- R6: With hours bit 6 at 0 (24-hour), hours count 00 to 23 in BCD (bit 5 holds the tens digit 2). 23:59:59 becomes 00:00:00 and carries into the day.
- R7: With hours bit 6 at 1 (12-hour), bit 5 is PM and bits 4:0 hold BCD 01 to 12. 11 becomes 12 with the PM bit toggled, and 12 becomes 01. Only 11:59:59 PM carries into the day, becoming 12:00:00 AM.
- R8: The date rolls to 01 and carries into the month after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after 28 in February, or after 29 when the year's value is divisible by four (year 00 included).
- R9: Month 12 rolls to 01 and increments the year. Year 99 rolls to 00.
- R10: The day of week steps on each day carry and wraps from 7 to 1.
- R11: The write addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. Bits that are fixed at zero read 0 whatever is written: minutes bit 7, hours bit 7, day bits 7:3, date bits 7:6 and month bits 7:5. Writes to address 7 change nothing.
- R12: In a cycle with a write, a tick that falls in that cycle is dropped, and only the written register changes.
- R13: A field holding a value at or above its legal maximum (for example seconds 0x5A) wraps to its first value on the next advance rather than sticking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 32.768 kHz enable, one clock cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Halt bit and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Format bit, PM or tens bit, BCD hours |
| dow_o | output | 8 | Day of week 1 to 7 |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| sec_pulse | output | 1 | High in the cycle where the calendar advances |

## Verification
All register outputs change at the rising edge that samples the enable completing the count, or at the edge that samples the write strobe, because no pipeline stage sits between the tick and the carry chain. `sec_pulse` is combinational and is valid during the enable's cycle. The bench drives inputs and samples outputs only at falling edges. It applies exactly `PRESCALE` enables after loading a state, so it reads each result half a cycle after the edge that produced it. The divider-restart and dropped-tick checks also stop one enable short of the period and confirm that nothing has moved yet.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } cal_regs_t;

    localparam logic [2:0] A_SEC   = 3'd0;
    localparam logic [2:0] A_MIN   = 3'd1;
    localparam logic [2:0] A_HOUR  = 3'd2;
    localparam logic [2:0] A_DOW   = 3'd3;
    localparam logic [2:0] A_DATE  = 3'd4;
    localparam logic [2:0] A_MONTH = 3'd5;
    localparam logic [2:0] A_YEAR  = 3'd6;

    // Packed-BCD increment; an out-of-range low digit carries to keep moving
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

endpackage

// File: rtl/bcdcal_prescaler.sv
module bcdcal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic halt,
    input  logic clr,
    output logic tick
);
    localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (en && !halt) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                tick  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_clear_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
    p_halt_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/bcdcal_hour_step.sv
module bcdcal_hour_step
    import bcdcal_pkg::*;
(
    input  logic [6:0] hour_cur,
    output logic [6:0] hour_nxt,
    output logic       day_wrap
);
    logic [4:0] h12;

    always_comb begin
        h12      = hour_cur[4:0];
        hour_nxt = hour_cur;
        day_wrap = 1'b0;
        if (hour_cur[6]) begin
            if (h12 == 5'h11) begin
                hour_nxt = {1'b1, ~hour_cur[5], 5'h12};
                day_wrap = hour_cur[5];
            end else if (h12 >= 5'h12) begin
                hour_nxt = {1'b1, hour_cur[5], 5'h01};
            end else begin
                hour_nxt = {1'b1, hour_cur[5], 5'(bcd_inc({3'd0, h12}))};
            end
        end else begin
            if (hour_cur[5:0] >= 6'h23) begin
                hour_nxt = 7'h00;
                day_wrap = 1'b1;
            end else begin
                hour_nxt = {1'b0, 6'(bcd_inc({2'd0, hour_cur[5:0]}))};
            end
        end
    end

endmodule

// File: rtl/bcdcal_month_len.sv
module bcdcal_month_len
    import bcdcal_pkg::*;
(
    input  logic [4:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_date
);
    logic [7:0] year_bin;
    logic       leap;

    always_comb begin
        year_bin = bcd_to_bin(year);
        leap     = (year_bin[1:0] == 2'b00);
        case (month)
            5'h02:                      last_date = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcdcal_top.sv
module bcdcal_top
    import bcdcal_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       sec_pulse
);
    localparam cal_regs_t RESET_REGS = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                         dow: 8'h01, date: 8'h01, month: 8'h01,
                                         year: 8'h00};

    cal_regs_t  regs_d, regs_q;
    logic       tick, adv, sec_wr;
    logic [6:0] hour_nxt;
    logic       hour_wrap;
    logic [7:0] last_date;
    logic       c_min, c_hr, c_day, c_mon, c_yr;

    assign sec_wr = wr_en && (wr_addr == A_SEC);
    assign adv    = tick && !wr_en;

    bcdcal_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .halt  (regs_q.sec[7]),
        .clr   (sec_wr),
        .tick  (tick)
    );

    bcdcal_hour_step u_hour (
        .hour_cur (regs_q.hour[6:0]),
        .hour_nxt (hour_nxt),
        .day_wrap (hour_wrap)
    );

    bcdcal_month_len u_mlen (
        .month     (regs_q.month[4:0]),
        .year      (regs_q.year),
        .last_date (last_date)
    );

    always_comb begin
        regs_d = regs_q;
        c_min  = 1'b0;
        c_hr   = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_yr   = 1'b0;
        if (adv) begin
            if (regs_q.sec[6:0] >= 7'h59) begin
                regs_d.sec = {regs_q.sec[7], 7'h00};
                c_min      = 1'b1;
            end else begin
                regs_d.sec = {regs_q.sec[7], 7'(bcd_inc({1'b0, regs_q.sec[6:0]}))};
            end
            if (c_min) begin
                if (regs_q.min[6:0] >= 7'h59) begin
                    regs_d.min = 8'h00;
                    c_hr       = 1'b1;
                end else begin
                    regs_d.min = {1'b0, 7'(bcd_inc({1'b0, regs_q.min[6:0]}))};
                end
            end
            if (c_hr) begin
                regs_d.hour = {1'b0, hour_nxt};
                c_day       = hour_wrap;
            end
            if (c_day) begin
                regs_d.dow = (regs_q.dow[2:0] >= 3'd7) ? 8'h01
                                                       : {5'd0, regs_q.dow[2:0] + 3'd1};
                if (regs_q.date >= last_date) begin
                    regs_d.date = 8'h01;
                    c_mon       = 1'b1;
                end else begin
                    regs_d.date = bcd_inc(regs_q.date);
                end
            end
            if (c_mon) begin
                if (regs_q.month >= 8'h12) begin
                    regs_d.month = 8'h01;
                    c_yr         = 1'b1;
                end else begin
                    regs_d.month = bcd_inc(regs_q.month);
                end
            end
            if (c_yr) begin
                regs_d.year = (regs_q.year >= 8'h99) ? 8'h00 : bcd_inc(regs_q.year);
            end
        end else if (wr_en) begin
            case (wr_addr)
                A_SEC:   regs_d.sec   = wr_data;
                A_MIN:   regs_d.min   = {1'b0, wr_data[6:0]};
                A_HOUR:  regs_d.hour  = {1'b0, wr_data[6:0]};
                A_DOW:   regs_d.dow   = {5'd0, wr_data[2:0]};
                A_DATE:  regs_d.date  = {2'd0, wr_data[5:0]};
                A_MONTH: regs_d.month = {3'd0, wr_data[4:0]};
                A_YEAR:  regs_d.year  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RESET_REGS;
        else        regs_q <= regs_d;
    end

    assign sec_o     = regs_q.sec;
    assign min_o     = regs_q.min;
    assign hour_o    = regs_q.hour;
    assign dow_o     = regs_q.dow;
    assign date_o    = regs_q.date;
    assign month_o   = regs_q.month;
    assign year_o    = regs_q.year;
    assign sec_pulse = adv;

    p_halt_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.sec[7] && !wr_en) |=> $stable(regs_q));
    p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && regs_q.sec[6:0] == 7'h59) |=> regs_q.sec[6:0] == 7'h00);
    p_hour12_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && regs_q.hour[6] && regs_q.sec[6:0] >= 7'h59 && regs_q.min[6:0] >= 7'h59)
        |=> (regs_q.hour[4:0] >= 5'h01 && regs_q.hour[4:0] <= 5'h12));
    p_date_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> regs_q.date != 8'h00);
    p_dow_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> (regs_q.dow >= 8'h01 && regs_q.dow <= 8'h07));
    p_fixed_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.min[7] | regs_q.hour[7] | (|regs_q.dow[7:3]) |
         (|regs_q.date[7:6]) | (|regs_q.month[7:5])) == 1'b0);
    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sec_pulse);

endmodule

// File: tb/bcdcal_top_bench.sv
module bcdcal_top_bench;
    localparam int P = 4;
    localparam int NV = 19;

    // {sec,min,hour,dow,date,month,year} loaded, then expected after one second
    localparam logic [111:0] VEC [NV] = '{
        112'h00000001010100_01000001010100,
        112'h59000001010100_00010001010100,
        112'h59592303150621_00000004160621,
        112'h59590902100307_00001002100307,
        112'h59595104200730_00007204200730,
        112'h59597107311299_00005201010100,
        112'h59597202050844_00006102050844,
        112'h59592305300422_00000006010522,
        112'h59592301280223_00000002010323,
        112'h59592301280224_00000002290224,
        112'h59592306290200_00000007010300,
        112'h59592307310105_00000001010205,
        112'h5A051003111111_00061003111111,
        112'h59592302300996_00000003011096,
        112'h59592302280296_00000003290296,
        112'h59592302280210_00000003010310,
        112'h59597103301150_00005204011250,
        112'h59591201010101_00001301010101,
        112'h59594901010101_00005001010101
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
    logic       sec_pulse;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bcdcal_top #(.PRESCALE(P)) u_bcdcal_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
        .year_o(year_o), .sec_pulse(sec_pulse)
    );

    function automatic logic [55:0] snap();
        return {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
    endfunction

    task automatic chk(input logic [55:0] act, input logic [55:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic load(input logic [55:0] v);
        wr(3'd1, v[47:40]); wr(3'd2, v[39:32]); wr(3'd3, v[31:24]);
        wr(3'd4, v[23:16]); wr(3'd5, v[15:8]);  wr(3'd6, v[7:0]);
        wr(3'd0, v[55:48]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        chk(snap(), 56'h00000001010100, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        chk(snap(), 56'h00000001010100, "R1 reset state held");

        // R2 R5 R6 R7 R8 R9 R10 R13: table walk
        for (int i = 0; i < NV; i++) begin
            load(VEC[i][111:56]);
            pulse(P);
            chk(snap(), VEC[i][55:0], $sformatf("R2 R5 R6 R7 R8 R9 R10 R13 vector %0d", i));
        end

        // R11 fixed-zero bits
        wr(3'd1, 8'hFF); chk({48'd0, min_o},   {48'd0, 8'h7F}, "R11 minutes mask");
        wr(3'd2, 8'hFF); chk({48'd0, hour_o},  {48'd0, 8'h7F}, "R11 hours mask");
        wr(3'd3, 8'hFF); chk({48'd0, dow_o},   {48'd0, 8'h07}, "R11 day mask");
        wr(3'd4, 8'hFF); chk({48'd0, date_o},  {48'd0, 8'h3F}, "R11 date mask");
        wr(3'd5, 8'hFF); chk({48'd0, month_o}, {48'd0, 8'h1F}, "R11 month mask");

        // R11 address 7 ignored
        load(56'h12345603150642);
        wr(3'd7, 8'hFF);
        chk(snap(), 56'h12345603150642, "R11 address 7 ignored");

        // R3 halt
        wr(3'd0, 8'h80);
        seen = 0;
        tick_en = 1'b1;
        repeat (3 * P) begin
            if (sec_pulse) seen++;
            @(negedge clk);
        end
        tick_en = 1'b0;
        chk({sec_o, 24'd0, 8'(seen)}, {8'h80, 32'd0}, "R3 halted no advance");
        wr(3'd0, 8'h00);
        pulse(P);
        chk({48'd0, sec_o}, {48'd0, 8'h01}, "R3 resume after halt cleared");

        // R4 seconds write restarts divider
        wr(3'd0, 8'h10);
        pulse(2);
        wr(3'd0, 8'h10);
        pulse(P - 1);
        chk({48'd0, sec_o}, {48'd0, 8'h10}, "R4 no early tick after write");
        pulse(1);
        chk({48'd0, sec_o}, {48'd0, 8'h11}, "R4 tick after full period");

        // R12 write drops coincident tick
        load(56'h20000001010100);
        pulse(P - 1);
        tick_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        chk({sec_o, min_o}, {8'h20, 8'h33}, "R12 write wins over tick");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule